// File: doc/BRIEF.md
# Interrupt Source PQ State Engine

This block holds a two-bit event state for each of `N` interrupt sources and a separate asserted flag for each source whose type is level-sensitive. Bit 1 of the state is P and bit 0 is Q. A caller sends at most one request per cycle. Each request names a source and an operation. Trigger, end-of-interrupt (EOI) and direct set act on the event state. The line-high and line-low operations report an edge on the source's input wire.

One cycle after an accepted request, the block returns the state that the source held before the request. In the same cycle it may raise a one-cycle notify strobe together with the source index, which tells a downstream router that a new event must be delivered. Repeated triggers are folded into the queued state. A level-sensitive source that is still asserted when its EOI arrives fires again on its own.

The per-source type map (`1` = level, `0` = message) is a static input. Reset does not alter it.

Top module: `pq_event_engine`

## Requirements
- R1: After reset every source holds state off (2'b01) and every asserted flag is clear, so an EOI on a level source set to 2'b00 raises no notify.
- R2: Trigger (op 3'd0). Reset 2'b00 goes to pending 2'b10 and notifies. Pending 2'b10 and queued 2'b11 both go to queued without notify. Off 2'b01 stays off without notify.
- R3: EOI (op 3'd1) on a source that is not an asserted level source. Reset and pending go to reset without notify. Queued goes to pending and notifies. Off stays off without notify.
- R4: Line-high (op 3'd3) on a level source sets its asserted flag. If the state was reset, it moves to pending and notifies. Any other state is left unchanged and no notify is raised.
- R5: Line-low (op 3'd4) on a level source clears its asserted flag, leaves the state unchanged and never notifies.
- R6: An EOI on a level source whose asserted flag is set first applies the R3 rule and then the R4 rule to the result. The notify comes only from the R4 step, so queued becomes pending with no notify, while reset or pending becomes pending with a notify.
- R7: Direct set (op 3'd2) writes `req_pq` as the new state, never notifies, and returns the previous state.
- R8: On a message source, line-high behaves exactly as a trigger, line-low has no effect, and the asserted flag is never set.
- R9: A request whose index is N or above, or whose op code is 3'd5 to 3'd7, changes no state and produces neither a response nor a notify.
- R10: Every accepted request gives `rsp_valid` and `rsp_old_pq` in the cycle after it. Any notify pulses in that same cycle, lasts one cycle, and carries the request's index on `notify_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 3 | 0 trigger, 1 EOI, 2 set, 3 line-high, 4 line-low |
| req_idx | input | IDX_W | Source index |
| req_pq | input | 2 | New state for a direct set |
| src_is_level | input | N | Per-source type, 1 = level-sensitive |
| rsp_valid | output | 1 | Response for the previous cycle's accepted request |
| rsp_old_pq | output | 2 | State the source held before that request |
| notify | output | 1 | One-cycle event strobe to the router |
| notify_idx | output | IDX_W | Source index for the notify |

## Verification
The hardest case to reach is the EOI re-fire. It needs a level source whose asserted flag is still set while its state is queued, pending or reset. Ordinary traffic seldom produces that combination, because line-high only sets the state when the source is in reset.

The stimulus gets there directly. For each source it first sets or clears the asserted flag with a line operation. It then forces every one of the four states with a direct set, and only then applies each operation. That sweep covers every combination of source type, flag value, state and operation, and a bench-side model predicts each result.

// File: rtl/pq_engine_pkg.sv
package pq_engine_pkg;

    typedef enum logic [1:0] {
        PQ_RESET  = 2'b00,
        PQ_OFF    = 2'b01,
        PQ_PEND   = 2'b10,
        PQ_QUEUED = 2'b11
    } pq_e;

    typedef enum logic [2:0] {
        OP_TRIG    = 3'd0,
        OP_EOI     = 3'd1,
        OP_SET     = 3'd2,
        OP_LINE_HI = 3'd3,
        OP_LINE_LO = 3'd4
    } op_e;

    localparam logic [2:0] OP_LAST = 3'd4;

endpackage

// File: rtl/pq_req_decode.sv
module pq_req_decode
    import pq_engine_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = 5
) (
    input  logic             req_valid,
    input  logic [2:0]       req_op,
    input  logic [IDX_W-1:0] req_idx,
    output logic             accept,
    output op_e              op
);
    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(N);

    logic idx_ok;
    logic op_ok;

    always_comb begin
        idx_ok = {1'b0, req_idx} < LIMIT;
        op_ok  = req_op <= OP_LAST;
        accept = req_valid && idx_ok && op_ok;
        op     = op_ok ? op_e'(req_op) : OP_TRIG;
    end
endmodule

// File: rtl/pq_transition.sv
module pq_transition
    import pq_engine_pkg::*;
(
    input  op_e        op,
    input  pq_e        cur,
    input  logic       asserted,
    input  logic       is_lvl,
    input  logic [1:0] set_val,
    output pq_e        nxt,
    output logic       nxt_asserted,
    output logic       fire
);
    pq_e  trig_pq;
    logic trig_fire;
    pq_e  eoi_pq;
    logic eoi_fire;

    // Trigger rule: events coalesce in the queued state
    always_comb begin
        unique case (cur)
            PQ_RESET:  begin trig_pq = PQ_PEND;   trig_fire = 1'b1; end
            PQ_PEND:   begin trig_pq = PQ_QUEUED; trig_fire = 1'b0; end
            PQ_QUEUED: begin trig_pq = PQ_QUEUED; trig_fire = 1'b0; end
            default:   begin trig_pq = PQ_OFF;    trig_fire = 1'b0; end
        endcase
    end

    // EOI rule: a queued event is released
    always_comb begin
        unique case (cur)
            PQ_RESET:  begin eoi_pq = PQ_RESET; eoi_fire = 1'b0; end
            PQ_PEND:   begin eoi_pq = PQ_RESET; eoi_fire = 1'b0; end
            PQ_QUEUED: begin eoi_pq = PQ_PEND;  eoi_fire = 1'b1; end
            default:   begin eoi_pq = PQ_OFF;   eoi_fire = 1'b0; end
        endcase
    end

    always_comb begin
        nxt          = cur;
        nxt_asserted = asserted;
        fire         = 1'b0;
        case (op)
            OP_TRIG: begin
                nxt  = trig_pq;
                fire = trig_fire;
            end
            OP_EOI: begin
                nxt  = eoi_pq;
                fire = eoi_fire;
                if (is_lvl && asserted) begin
                    // level still high: line rule decides the strobe
                    fire = (eoi_pq == PQ_RESET);
                    nxt  = (eoi_pq == PQ_RESET) ? PQ_PEND : eoi_pq;
                end
            end
            OP_SET: begin
                nxt = pq_e'(set_val);
            end
            OP_LINE_HI: begin
                if (is_lvl) begin
                    nxt_asserted = 1'b1;
                    fire         = (cur == PQ_RESET);
                    nxt          = (cur == PQ_RESET) ? PQ_PEND : cur;
                end else begin
                    nxt  = trig_pq;
                    fire = trig_fire;
                end
            end
            OP_LINE_LO: begin
                if (is_lvl) begin
                    nxt_asserted = 1'b0;
                end
            end
            default: begin
                nxt = cur;
            end
        endcase
    end
endmodule

// File: rtl/pq_state_store.sv
module pq_state_store
    import pq_engine_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  pq_e              wr_pq,
    input  logic             wr_asserted,
    input  logic [IDX_W-1:0] rd_idx,
    output pq_e              rd_pq,
    output logic             rd_asserted
);
    pq_e  pq_q [N];
    logic as_q [N];

    for (genvar g = 0; g < N; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pq_q[g] <= PQ_OFF;
                as_q[g] <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                pq_q[g] <= wr_pq;
                as_q[g] <= wr_asserted;
            end
        end
    end

    always_comb begin
        rd_pq       = PQ_OFF;
        rd_asserted = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_pq       = pq_q[i];
                rd_asserted = as_q[i];
            end
        end
    end
endmodule

// File: rtl/pq_event_engine.sv
module pq_event_engine
    import pq_engine_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_op,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [1:0]       req_pq,
    input  logic [N-1:0]     src_is_level,
    output logic             rsp_valid,
    output logic [1:0]       rsp_old_pq,
    output logic             notify,
    output logic [IDX_W-1:0] notify_idx
);
    logic accept;
    op_e  op;
    pq_e  cur_pq;
    logic cur_as;
    logic is_lvl;
    pq_e  nxt_pq;
    logic nxt_as;
    logic fire;

    pq_req_decode #(.N(N), .IDX_W(IDX_W)) u_dec (
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_idx   (req_idx),
        .accept    (accept),
        .op        (op)
    );

    pq_state_store #(.N(N), .IDX_W(IDX_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (accept),
        .wr_idx      (req_idx),
        .wr_pq       (nxt_pq),
        .wr_asserted (nxt_as),
        .rd_idx      (req_idx),
        .rd_pq       (cur_pq),
        .rd_asserted (cur_as)
    );

    always_comb begin
        is_lvl = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req_idx == IDX_W'(i)) is_lvl = src_is_level[i];
        end
    end

    pq_transition u_fsm (
        .op           (op),
        .cur          (cur_pq),
        .asserted     (cur_as),
        .is_lvl       (is_lvl),
        .set_val      (req_pq),
        .nxt          (nxt_pq),
        .nxt_asserted (nxt_as),
        .fire         (fire)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_old_pq <= PQ_OFF;
            notify     <= 1'b0;
            notify_idx <= '0;
        end else begin
            rsp_valid  <= accept;
            rsp_old_pq <= accept ? cur_pq : PQ_OFF;
            notify     <= accept && fire;
            notify_idx <= (accept && fire) ? req_idx : '0;
        end
    end
endmodule

// File: rtl/pq_event_engine_chk.sv
module pq_event_engine_chk #(
    parameter int N     = 16,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [2:0]       req_op,
    input logic [IDX_W-1:0] req_idx,
    input logic             rsp_valid,
    input logic [1:0]       rsp_old_pq,
    input logic             notify,
    input logic [IDX_W-1:0] notify_idx
);
    AST_NOTIFY_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        notify |-> rsp_valid); // R10
    AST_NOTIFY_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && rst_n |=> (!notify || notify_idx == $past(req_idx))); // R10
    AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid)); // R10
    AST_BAD_REQ_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && ({1'b0, req_idx} >= (IDX_W+1)'(N) || req_op > 3'd4)
        |=> !rsp_valid && !notify); // R9
    AST_SET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == 3'd2 |=> !notify); // R7
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_old_pq == 2'b01 |-> !notify); // R2
    AST_LINE_LO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == 3'd4 |=> !notify); // R5
endmodule

bind pq_event_engine pq_event_engine_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_idx    (req_idx),
    .rsp_valid  (rsp_valid),
    .rsp_old_pq (rsp_old_pq),
    .notify     (notify),
    .notify_idx (notify_idx)
);

// File: tb/pq_event_engine_test.sv
module pq_event_engine_test;
    localparam int N     = 16;
    localparam int IDX_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [2:0]       req_op = '0;
    logic [IDX_W-1:0] req_idx = '0;
    logic [1:0]       req_pq = '0;
    logic [N-1:0]     src_is_level = 16'b1010_0110_1100_0011;
    logic             rsp_valid;
    logic [1:0]       rsp_old_pq;
    logic             notify;
    logic [IDX_W-1:0] notify_idx;

    int checks = 0;
    int errors = 0;
    logic [1:0] mpq [N];
    logic       mas [N];

    always #10 clk = ~clk;

    pq_event_engine #(.N(N), .IDX_W(IDX_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_idx(req_idx), .req_pq(req_pq), .src_is_level(src_is_level),
        .rsp_valid(rsp_valid), .rsp_old_pq(rsp_old_pq),
        .notify(notify), .notify_idx(notify_idx)
    );

    task automatic model(input logic [2:0] op, input logic [1:0] old,
                         input logic as, input logic lvl, input logic [1:0] v,
                         output logic [1:0] nw, output logic nas,
                         output logic fire);
        nw = old; nas = as; fire = 1'b0;
        case (op)
            3'd0, 3'd3: begin
                if (op == 3'd3 && lvl) begin
                    nas = 1'b1;
                    if (old == 2'b00) begin nw = 2'b10; fire = 1'b1; end
                end else if (old == 2'b00) begin nw = 2'b10; fire = 1'b1; end
                else if (old != 2'b01) nw = 2'b11;
            end
            3'd1: begin
                if (old == 2'b11) begin nw = 2'b10; fire = 1'b1; end
                else if (old != 2'b01) nw = 2'b00;
                if (lvl && as) begin
                    fire = (nw == 2'b00);
                    if (nw == 2'b00) nw = 2'b10;
                end
            end
            3'd2: nw = v;
            3'd4: if (lvl) nas = 1'b0;
            default: ;
        endcase
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic req(input logic [2:0] op, input int idx,
                       input logic [1:0] v, input string tag);
        logic acc, e_fire, nas;
        logic [1:0] e_old, nw;
        acc = (idx < N) && (op <= 3'd4);
        e_old = 2'b01; e_fire = 1'b0;
        if (acc) begin
            e_old = mpq[idx];
            model(op, mpq[idx], mas[idx], src_is_level[idx], v, nw, nas, e_fire);
            mpq[idx] = nw;
            mas[idx] = nas;
        end
        req_valid = 1'b1; req_op = op; req_idx = IDX_W'(idx); req_pq = v;
        @(negedge clk);
        req_valid = 1'b0;
        checks++;
        if (rsp_valid !== acc || (acc && rsp_old_pq !== e_old) ||
            notify !== e_fire || (e_fire && notify_idx !== IDX_W'(idx))) begin
            errors++;
            $display("FAIL %s op=%0d idx=%0d: got v=%b old=%b n=%b ni=%0d, exp v=%b old=%b n=%b ni=%0d",
                     tag, op, idx, rsp_valid, rsp_old_pq, notify, notify_idx,
                     acc, e_old, e_fire, idx);
        end
    endtask

    function automatic string tag_of(input logic [2:0] op, input logic lvl,
                                     input logic as);
        case (op)
            3'd0: return "R2";
            3'd1: return (lvl && as) ? "R6" : "R3";
            3'd2: return "R7";
            3'd3: return lvl ? "R4" : "R8";
            default: return lvl ? "R5" : "R8";
        endcase
    endfunction

    initial begin
        for (int i = 0; i < N; i++) begin mpq[i] = 2'b01; mas[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: every source reads back off; flags clear
        for (int s = 0; s < N; s++) req(3'd2, s, 2'b01, "R1");
        req(3'd2, 0, 2'b00, "R1");
        req(3'd1, 0, 2'b00, "R1");
        // exhaustive sweep: type x flag x state x op
        for (int s = 0; s < N; s++)
            for (int a = 0; a < 2; a++)
                for (int p = 0; p < 4; p++)
                    for (int o = 0; o < 5; o++) begin
                        req(a ? 3'd3 : 3'd4, s, 2'b00, "R10");
                        req(3'd2, s, 2'(p), "R7");
                        req(3'(o), s, 2'b00,
                            tag_of(3'(o), src_is_level[s], mas[s]));
                    end
        // R9: bad index and bad op code leave state untouched
        for (int s = 0; s < N; s++) req(3'd2, s, 2'b00, "R7");
        for (int s = N; s < 32; s++) req(3'd0, s, 2'b00, "R9");
        for (int o = 5; o < 8; o++) req(3'(o), 3, 2'b00, "R9");
        for (int s = 0; s < N; s++) req(3'd2, s, 2'b00, "R9");
        // R10: back-to-back notifies carry each index
        for (int s = 0; s < N; s++) req(3'd0, s, 2'b00, "R10");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, exp completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule